// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one parallel I/O port of configurable width (3 to 8 pins) that sits on a simple register bus. Each pin has a direction bit and an output latch bit. A pin whose direction bit is 0 drives its latch bit onto the pad. A pin whose direction bit is 1 releases the pad and acts as an input. Pad inputs pass through a two-flop synchronizer before software can read them. A read of the data register therefore returns the live pin levels, not the latch contents.

The bus has one request per cycle, qualified by `bus_valid_i`, and selects one of four targets with `bus_addr_i`. The data register writes the whole latch. The direction register is written and read as a whole. The bit-set and bit-clear commands take a bit index in write data bits [2:0] and change exactly one latch bit in a single clock. Read data is registered and holds its value between reads.

Top module: `gpio_port`

## Requirements
- R1: While `rst_ni` is low and after it rises, all direction bits are 1 (all pins input), the latch is 0, `pad_oe_o` is 0, `pad_out_o` is 0 and `bus_rdata_o` is 0.
- R2: `pad_oe_o[i]` is 1 exactly when direction bit i is 0.
- R3: `pad_out_o[i]` equals latch bit i while `pad_oe_o[i]` is 1, and is 0 otherwise.
- R4: A write to address 0 loads write data bits [NUM_PINS-1:0] into the latch at that clock edge. Pins configured as inputs stay undriven.
- R5: A read of address 0 sets `bus_rdata_o` after the read's clock edge. The value is the `pad_in_i` level present two clock edges before the read's edge, zero-extended to 8 bits.
- R6: A read of address 1 returns the direction register, zero-extended to 8 bits.
- R7: A write to address 2 sets the latch bit indexed by write data [2:0] in one clock and leaves all other latch bits unchanged.
- R8: A write to address 3 clears the latch bit indexed by write data [2:0] in one clock and leaves all other latch bits unchanged.
- R9: A set or clear command whose index is NUM_PINS or greater leaves the latch unchanged.
- R10: `bus_rdata_o` keeps its value in every cycle without a read. A read of address 2 or 3 returns 0.
- R11: A write to address 1 loads write data bits [NUM_PINS-1:0] into the direction register at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request in this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | 0 data, 1 direction, 2 bit set, 3 bit clear |
| bus_wdata_i | input | 8 | Write data or bit index in [2:0] |
| bus_rdata_o | output | 8 | Registered read data |
| pad_in_i | input | NUM_PINS | Pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |

## Verification
Two events can fall in the same cycle: an edge on a pad input and a read of the data register. The bench changes the externally driven pad levels on the same clock edge that issues data-register reads, both in directed steps and in a long mixed run. Its model delays each pad level by exactly two edges and expects the read to return the older level. A second collision is a bit set on a pin that is configured as an input. The bench judges it by the pad staying undriven until a later direction write exposes the bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W = 8;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_BSET = 2'd2,
    SEL_BCLR = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  reg_sel_e            sel_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] latch_o
);
  localparam logic [IDX_W:0] PINS_L = (IDX_W+1)'(NUM_PINS);

  logic [NUM_PINS-1:0] dir_q, latch_q, latch_d, bit_mask;
  logic [IDX_W-1:0]    idx;
  logic                idx_ok;

  assign idx      = wdata_i[IDX_W-1:0];
  assign idx_ok   = {1'b0, idx} < PINS_L;
  assign bit_mask = {{(NUM_PINS-1){1'b0}}, 1'b1} << idx;

  always_comb begin
    latch_d = latch_q;
    if (wr_i) begin
      unique case (sel_i)
        SEL_DATA: latch_d = wdata_i[NUM_PINS-1:0];
        SEL_BSET: if (idx_ok) latch_d = latch_q | bit_mask;
        SEL_BCLR: if (idx_ok) latch_d = latch_q & ~bit_mask;
        default:  latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '1;
      latch_q <= '0;
    end else begin
      latch_q <= latch_d;
      if (wr_i && sel_i == SEL_DIR) dir_q <= wdata_i[NUM_PINS-1:0];
    end
  end

  assign dir_o   = dir_q;
  assign latch_o = latch_q;

  a_r7_set_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_BSET && idx_ok) |=>
      (latch_q[$past(idx)] && ((latch_q ^ $past(latch_q)) & ~$past(bit_mask)) == '0));
  a_r8_clear_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SEL_BCLR && idx_ok) |=>
      (!latch_q[$past(idx)] && ((latch_q ^ $past(latch_q)) & ~$past(bit_mask)) == '0));
  a_r9_bad_index_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (sel_i == SEL_BSET || sel_i == SEL_BCLR) && !idx_ok) |=> $stable(latch_q));
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  reg_sel_e            sel_i,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] dir_i,
  output logic [BUS_W-1:0]    rdata_o
);
  logic [BUS_W-1:0] rdata_q, rdata_d;

  always_comb begin
    unique case (sel_i)
      SEL_DATA: rdata_d = BUS_W'(pins_i);
      SEL_DIR:  rdata_d = BUS_W'(dir_i);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r10_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
  a_r5_read_returns_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == SEL_DATA) |=> rdata_q == BUS_W'($past(pins_i)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [1:0]          bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  initial begin
    if (NUM_PINS < 3 || NUM_PINS > BUS_W) $error("NUM_PINS out of range");
  end

  reg_sel_e            sel;
  logic                wr, rd;
  logic [NUM_PINS-1:0] dir, latch, pins_sync;

  assign sel = reg_sel_e'(bus_addr_i);
  assign wr  = bus_valid_i && bus_write_i;
  assign rd  = bus_valid_i && !bus_write_i;

  gpio_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .sel_i(sel), .wdata_i(bus_wdata_i),
    .dir_o(dir), .latch_o(latch)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pins_sync)
  );

  gpio_rdmux #(.NUM_PINS(NUM_PINS)) u_rdmux (
    .clk_i, .rst_ni, .rd_i(rd), .sel_i(sel), .pins_i(pins_sync),
    .dir_i(dir), .rdata_o(bus_rdata_o)
  );

  assign pad_oe_o  = ~dir;
  assign pad_out_o = latch & ~dir;

  a_r2_oe_follows_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DIR) |=> pad_oe_o == ~$past(bus_wdata_i[NUM_PINS-1:0]));
  a_r3_no_drive_on_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  a_r4_data_write_to_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_DATA) |=> (pad_out_o == ($past(bus_wdata_i[NUM_PINS-1:0]) & pad_oe_o)));
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  localparam int W = 6;

  logic clk = 0, rst_n = 0;
  logic valid = 0, write = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [W-1:0] ext = '0, pad_in, pad_out, pad_oe;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_tag = "R10";

  always #2 clk = ~clk;

  gpio_port #(.NUM_PINS(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // pad resolution: driven pins show the driven value, others the external level
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  // reference model
  logic [W-1:0] dir_m = '1, lat_m = '0;
  logic [7:0]   rd_m = '0;
  logic [W-1:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_m <= '1; lat_m <= '0; rd_m <= '0;
      hist = {};
      hist.push_back('0); hist.push_back('0);
    end else begin
      logic [W-1:0] pin_now, synced;
      pin_now = (~dir_m & lat_m) | (dir_m & ext);
      synced = hist[0];
      if (valid && !write) begin
        if (addr == 2'd0)      rd_m <= 8'(synced);
        else if (addr == 2'd1) rd_m <= 8'(dir_m);
        else                   rd_m <= 8'h00;
      end
      if (valid && write) begin
        int ix;
        ix = int'(wdata[2:0]);
        case (addr)
          2'd0: lat_m <= wdata[W-1:0];
          2'd1: dir_m <= wdata[W-1:0];
          2'd2: if (ix < W) lat_m[ix] <= 1'b1;
          default: if (ix < W) lat_m[ix] <= 1'b0;
        endcase
      end
      void'(hist.pop_front());
      hist.push_back(pin_now);
    end
  end

  task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pad_oe == ~dir_m, "R2", 8'(pad_oe), 8'(~dir_m));
      check(pad_out == (lat_m & ~dir_m), "R3", 8'(pad_out), 8'(lat_m & ~dir_m));
      check(rdata == rd_m, cur_tag, rdata, rd_m);
    end
  end

  task automatic op(bit wr, logic [1:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    cur_tag = tag; valid = 1; write = wr; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; write = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pad_oe == '0 && pad_out == '0 && rdata == '0, "R1", 8'(pad_oe), 8'h00);
    rst_n = 1;
    @(negedge clk);
    check(pad_oe == '0 && pad_out == '0 && rdata == '0, "R1", rdata, 8'h00);

    ext = 6'b101010;
    repeat (3) op(0, 2'd0, 8'h00, "R5");
    // pad edge on the same cycle as a data read
    @(negedge clk); ext = 6'b010101; cur_tag = "R5"; valid = 1; write = 0; addr = 0;
    repeat (3) @(negedge clk);
    valid = 0;
    op(0, 2'd0, 8'h00, "R5");
    check(rdata == 8'h15, "R5", rdata, 8'h15);

    op(0, 2'd1, 8'h00, "R6");
    check(rdata == 8'h3F, "R6", rdata, 8'h3F);
    op(1, 2'd0, 8'hFF, "R4");
    check(pad_out == '0 && pad_oe == '0, "R4", 8'(pad_out), 8'h00);
    op(1, 2'd1, 8'h30, "R11");
    check(pad_oe == 6'h0F, "R11", 8'(pad_oe), 8'h0F);
    op(0, 2'd1, 8'h00, "R6");
    check(rdata == 8'h30, "R6", rdata, 8'h30);
    op(1, 2'd0, 8'h05, "R4");
    check(pad_out == 6'h05, "R4", 8'(pad_out), 8'h05);
    op(1, 2'd2, 8'h01, "R7");
    check(pad_out == 6'h07, "R7", 8'(pad_out), 8'h07);
    op(1, 2'd3, 8'h00, "R8");
    check(pad_out == 6'h06, "R8", 8'(pad_out), 8'h06);
    op(1, 2'd2, 8'h07, "R9");
    check(pad_out == 6'h06, "R9", 8'(pad_out), 8'h06);
    op(1, 2'd3, 8'hF6, "R9");
    check(pad_out == 6'h06, "R9", 8'(pad_out), 8'h06);
    op(1, 2'd2, 8'h05, "R7");
    check(pad_out == 6'h06, "R7", 8'(pad_out), 8'h06);
    op(1, 2'd1, 8'h00, "R11");
    check(pad_out == 6'h26, "R7", 8'(pad_out), 8'h26);
    op(0, 2'd0, 8'h00, "R5");
    op(0, 2'd0, 8'h00, "R5");
    check(rdata == 8'h26, "R5", rdata, 8'h26);
    op(0, 2'd2, 8'h00, "R10");
    check(rdata == 8'h00, "R10", rdata, 8'h00);
    op(0, 2'd1, 8'h00, "R6");
    repeat (3) @(negedge clk);
    check(rdata == 8'h00, "R10", rdata, 8'h00);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      cur_tag = "R5";
      ext   = W'($urandom);
      valid = 1'($urandom);
      write = 1'($urandom);
      addr  = 2'($urandom);
      wdata = 8'($urandom);
    end
    @(negedge clk); valid = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule